// File: doc/BRIEF.md
# Indirect-Access Host Register Bridge

This block sits between a byte-wide host port with a two-bit location select and a larger set of internal registers. Four locations are reached directly: a pointer to an internal register, a data window onto the register the pointer selects, a read port onto the head of a receive FIFO, and a status/interrupt register. Any internal register is reached in two steps. The host first writes its address into the pointer, then reads or writes the data window.

Internal addresses fall into three groups. The slow region, 0x00 to 0x8F, sits behind a request/acknowledge link whose latency is long and varies. A slow read is launched at the moment the pointer is written. Its result is held in a buffer, and a later read of the window returns it. A slow write is launched when the window is written. The fast bank, 0x90 to 0xCF, is a local register file that answers at once. Addresses 0xD0 to 0xFF are unmapped. When a slow access finishes, a cycle-complete flag is set. The flag can raise an interrupt when the enable bit in the fast register 0xC1 is set. The host polls the flag or waits for the interrupt before it reads a slow result or starts the next slow access.

Host strobes are synchronous single-cycle pulses. The FIFO side is a valid/ready stream. A pop happens only on a cycle where `fifo_valid` and `fifo_ready` are both high. The block raises `fifo_ready` only during a host read of location 2'b10, so the FIFO can hold its head for as long as it likes. A read made while `fifo_valid` is low pops nothing.

Top module: `hostbr_top`

## Requirements
- R1: After reset, `host_rvalid`, `slow_req` and `irq` are low, the status register reads 0x00, and every fast register reads 0x00.
- R2: A host read strobe at a clock edge gives `host_rvalid` high for one cycle after that edge, with the read byte on `host_rdata`. Location 2'b00 returns the pointer. 2'b01 returns the register the pointer selects. 2'b10 returns the FIFO head. 2'b11 returns the status register.
- R3: A window write while the pointer is in 0x90–0xCF stores the byte, and a window read returns it. Fast accesses never raise `slow_req` and never change the status register.
- R4: A window read while the pointer is in 0xD0–0xFF returns 0x00. A window write there changes nothing.
- R5: A pointer write of an address in 0x00–0x8F raises `slow_req` with `slow_we`=0 and `slow_addr` equal to that address. The request is held until `slow_ack` is seen. The byte on `slow_rdata` in the acknowledge cycle becomes the value of later window reads while the pointer stays slow.
- R6: A window write while the pointer is slow raises `slow_req` with `slow_we`=1, `slow_addr` equal to the pointer and `slow_wdata` equal to the written byte.
- R7: Status bit 0 (cycle complete) is set by each slow acknowledge. A status write with bit 0 set clears it, and launching a new slow access clears it. Status bit 1 (busy) is high while a slow request is pending. Status bits 7..2 read 0.
- R8: A slow launch, by pointer or by window, made while a request is pending is dropped. The pending request and its address are unchanged, and no extra request follows.
- R9: `irq` is high exactly when status bit 0 is set and bit 0 of fast register 0xC1 is set.
- R10: A host read of 2'b10 drives `fifo_ready` high in that cycle. It returns `fifo_data` if `fifo_valid` is high, and 0x00 with no pop if it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_stb | input | 1 | Single-cycle host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Direct location select |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read result valid, one cycle after the strobe |
| fifo_valid | input | 1 | FIFO head available |
| fifo_data | input | 8 | FIFO head byte |
| fifo_ready | output | 1 | Pop handshake: consumes the head when fifo_valid is high |
| slow_req | output | 1 | Slow-side request, held until acknowledge |
| slow_we | output | 1 | Slow-side write select |
| slow_addr | output | 8 | Slow-side register address |
| slow_wdata | output | 8 | Slow-side write byte |
| slow_ack | input | 1 | Slow-side completion, one cycle |
| slow_rdata | input | 8 | Slow-side read byte, valid with slow_ack |
| irq | output | 1 | Cycle-complete interrupt |

## Verification
The bench uses the default parameters: an 8-bit bus, the slow region up to 0x8F, the fast bank from 0x90 to 0xCF, and the enable register at 0xC1. These defaults place both ends of the fast bank and the unmapped area above it within a few host accesses. The slow-side model answers after a random delay of 4 to 15 cycles. A status read made just after a launch therefore always finds the request pending. That lets the bench launch a second request while the first is busy and confirm that it is dropped.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    LOC_PTR  = 2'b00,
    LOC_WIN  = 2'b01,
    LOC_FIFO = 2'b10,
    LOC_STAT = 2'b11
  } hb_loc_e;

  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_BUSY_BIT = 1;
endpackage

// File: rtl/hb_fast_bank.sv
module hb_fast_bank #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] LO = 'h90,
  parameter logic [AW-1:0] HI = 'hCF,
  parameter logic [AW-1:0] TAP_ADDR = 'hC1,
  parameter int unsigned TAP_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          tap_bit
);
  localparam int unsigned DEPTH = int'(HI) - int'(LO) + 1;
  localparam int unsigned TAP   = int'(TAP_ADDR) - int'(LO);

  logic [DW-1:0] regs [DEPTH];
  logic [AW-1:0] woff, roff;
  logic          whit, rhit;

  assign woff = waddr - LO;
  assign roff = raddr - LO;
  assign whit = (waddr >= LO) && (waddr <= HI);
  assign rhit = (raddr >= LO) && (raddr <= HI);

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                regs[i] <= '0;
      else if (we && whit && woff == AW'(i))     regs[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rhit && roff == AW'(i)) rdata = regs[i];
  end

  assign tap_bit = regs[TAP][TAP_BIT];

  // R4: a write outside the bank leaves the tapped register alone
  a_r4_outside_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !whit) |=> $stable(tap_bit));
endmodule

// File: rtl/hb_slow_link.sv
module hb_slow_link #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          launch_we,
  input  logic [AW-1:0] launch_addr,
  input  logic [DW-1:0] launch_wdata,
  input  logic          clr_done,
  output logic          slow_req,
  output logic          slow_we,
  output logic [AW-1:0] slow_addr,
  output logic [DW-1:0] slow_wdata,
  input  logic          slow_ack,
  input  logic [DW-1:0] slow_rdata,
  output logic          done,
  output logic [DW-1:0] rd_buf
);
  logic finish, accept;
  assign finish = slow_req && slow_ack;
  assign accept = launch && !slow_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slow_req   <= 1'b0;
      slow_we    <= 1'b0;
      slow_addr  <= '0;
      slow_wdata <= '0;
      rd_buf     <= '0;
    end else if (finish) begin
      slow_req <= 1'b0;
      if (!slow_we) rd_buf <= slow_rdata;
    end else if (accept) begin
      slow_req   <= 1'b1;
      slow_we    <= launch_we;
      slow_addr  <= launch_addr;
      slow_wdata <= launch_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        done <= 1'b0;
    else if (finish)   done <= 1'b1;
    else if (accept)   done <= 1'b0;
    else if (clr_done) done <= 1'b0;
  end

  // R5: request held until acknowledged, address steady meanwhile
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_req && !slow_ack) |=> slow_req);
  a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_req && !slow_ack) |=> $stable(slow_addr));
  // R8: a launch while pending does not alter direction or data
  a_r8_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_req && !slow_ack && launch) |=> ($stable(slow_we) && $stable(slow_wdata)));
  // R7: completion flag rises only from an acknowledge; launch clears it
  a_r7_done_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(slow_req && slow_ack));
  a_r7_launch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slow_req) |-> !done);
endmodule

// File: rtl/hostbr_top.sv
module hostbr_top #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] SLOW_HI  = 'h8F,
  parameter logic [AW-1:0] FAST_LO  = 'h90,
  parameter logic [AW-1:0] FAST_HI  = 'hCF,
  parameter logic [AW-1:0] IEN_ADDR = 'hC1,
  parameter int unsigned   IEN_BIT  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_stb,
  input  logic          host_we,
  input  logic [1:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rvalid,
  input  logic          fifo_valid,
  input  logic [DW-1:0] fifo_data,
  output logic          fifo_ready,
  output logic          slow_req,
  output logic          slow_we,
  output logic [AW-1:0] slow_addr,
  output logic [DW-1:0] slow_wdata,
  input  logic          slow_ack,
  input  logic [DW-1:0] slow_rdata,
  output logic          irq
);
  import hb_pkg::*;

  hb_loc_e       loc;
  logic          wr, rd;
  logic [AW-1:0] ptr;
  logic          ptr_slow, new_slow;
  logic          launch_rd, launch_wr;
  logic          done, ien;
  logic [DW-1:0] fast_rdata, rd_buf, rd_next, status;

  assign loc      = hb_loc_e'(host_addr);
  assign wr       = host_stb && host_we;
  assign rd       = host_stb && !host_we;
  assign ptr_slow = (ptr <= SLOW_HI);
  assign new_slow = (AW'(host_wdata) <= SLOW_HI);

  always_ff @(posedge clk) begin
    if (!rst_n)                     ptr <= '0;
    else if (wr && loc == LOC_PTR)  ptr <= AW'(host_wdata);
  end

  assign launch_rd = wr && (loc == LOC_PTR) && new_slow;
  assign launch_wr = wr && (loc == LOC_WIN) && ptr_slow;

  hb_slow_link #(.AW(AW), .DW(DW)) u_link (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch_rd || launch_wr),
    .launch_we    (launch_wr),
    .launch_addr  (launch_rd ? AW'(host_wdata) : ptr),
    .launch_wdata (host_wdata),
    .clr_done     (wr && (loc == LOC_STAT) && host_wdata[STAT_DONE_BIT]),
    .slow_req     (slow_req),
    .slow_we      (slow_we),
    .slow_addr    (slow_addr),
    .slow_wdata   (slow_wdata),
    .slow_ack     (slow_ack),
    .slow_rdata   (slow_rdata),
    .done         (done),
    .rd_buf       (rd_buf)
  );

  hb_fast_bank #(
    .AW(AW), .DW(DW), .LO(FAST_LO), .HI(FAST_HI),
    .TAP_ADDR(IEN_ADDR), .TAP_BIT(IEN_BIT)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr && (loc == LOC_WIN) && !ptr_slow),
    .waddr   (ptr),
    .wdata   (host_wdata),
    .raddr   (ptr),
    .rdata   (fast_rdata),
    .tap_bit (ien)
  );

  always_comb begin
    status = '0;
    status[STAT_DONE_BIT] = done;
    status[STAT_BUSY_BIT] = slow_req;
  end

  assign fifo_ready = rd && (loc == LOC_FIFO);

  always_comb begin
    unique case (loc)
      LOC_PTR:  rd_next = DW'(ptr);
      LOC_WIN:  rd_next = ptr_slow ? rd_buf : fast_rdata;
      LOC_FIFO: rd_next = fifo_valid ? fifo_data : '0;
      default:  rd_next = status;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd;
      if (rd) host_rdata <= rd_next;
    end
  end

  assign irq = done && ien;

  // R2: every read strobe yields a result one cycle later
  a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (host_stb && !host_we) |=> host_rvalid);
  // R3: fast-bank traffic never launches a slow request
  a_r3_fast_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!slow_req && wr && loc == LOC_WIN && !ptr_slow) |=> !slow_req);
endmodule

// File: tb/hostbr_top_bench.sv
module hostbr_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_stb = 1'b0, host_we = 1'b0;
  logic [1:0] host_addr = 2'b00;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       host_rvalid;
  logic       fifo_valid = 1'b0;
  logic [7:0] fifo_data = 8'h00;
  logic       fifo_ready;
  logic       slow_req, slow_we;
  logic [7:0] slow_addr, slow_wdata;
  logic       slow_ack = 1'b0;
  logic [7:0] slow_rdata = 8'h00;
  logic       irq;

  int errors = 0, checks = 0, pops = 0, acks = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [16:0] req_q[$];   // {we, addr, wdata}

  always #10 clk = ~clk;   // 50 MHz

  hostbr_top u_hostbr_top (
    .clk(clk), .rst_n(rst_n), .host_stb(host_stb), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_ready(fifo_ready), .slow_req(slow_req), .slow_we(slow_we),
    .slow_addr(slow_addr), .slow_wdata(slow_wdata), .slow_ack(slow_ack),
    .slow_rdata(slow_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_stb = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_stb = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    host_stb = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_req(input logic we, input logic [7:0] a, input logic [7:0] d);
    req_q.push_back({we, a, d});
  endtask

  task automatic wait_acks(input int n);
    while (acks < n) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] slow_val(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  // scoreboard monitor for host reads
  always @(negedge clk) begin
    if (host_rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected rvalid", host_rdata, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(host_rdata === e, t, host_rdata, e);
      end
    end
  end

  always @(posedge clk) if (fifo_valid && fifo_ready) pops++;

  // slow-side agent with random latency
  initial begin
    forever begin
      @(negedge clk);
      if (slow_req) begin
        if (req_q.size() == 0) chk(1'b0, "R8 unexpected slow request", slow_addr, 0);
        else begin
          logic [16:0] e;
          e = req_q.pop_front();
          chk(slow_we === e[16] && slow_addr === e[15:8],
              "R5 R6 slow request kind/address", {slow_we, slow_addr}, e[16:8]);
          if (e[16]) chk(slow_wdata === e[7:0], "R6 slow write data", slow_wdata, e[7:0]);
        end
        begin
          int lat;
          lat = $urandom_range(15, 4);
          repeat (lat - 1) @(negedge clk);
        end
        slow_rdata = slow_val(slow_addr);
        slow_ack = 1'b1;
        @(negedge clk);
        slow_ack = 1'b0;
        acks++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(host_rvalid === 1'b0, "R1 rvalid after reset", host_rvalid, 0);
    chk(slow_req === 1'b0, "R1 slow_req after reset", slow_req, 0);
    chk(irq === 1'b0, "R1 irq after reset", irq, 0);
    host_read(2'b11, 8'h00, "R1 status after reset");
    host_write(2'b00, 8'hA5);
    host_read(2'b01, 8'h00, "R1 fast register after reset");
    // R2 pointer readback
    host_read(2'b00, 8'hA5, "R2 pointer readback");
    // R3 fast bank edges and middle
    host_write(2'b00, 8'h90); host_write(2'b01, 8'h11);
    host_write(2'b00, 8'hCF); host_write(2'b01, 8'hEE);
    host_write(2'b00, 8'hB3); host_write(2'b01, 8'h3C);
    host_write(2'b00, 8'h90); host_read(2'b01, 8'h11, "R3 fast low edge");
    host_write(2'b00, 8'hCF); host_read(2'b01, 8'hEE, "R3 fast high edge");
    host_write(2'b00, 8'hB3); host_read(2'b01, 8'h3C, "R3 fast middle");
    host_read(2'b11, 8'h00, "R3 status after fast traffic");
    // R4 unmapped
    host_write(2'b00, 8'hD0); host_write(2'b01, 8'h55);
    host_read(2'b01, 8'h00, "R4 unmapped low read");
    host_write(2'b00, 8'hFF); host_write(2'b01, 8'h66);
    host_read(2'b01, 8'h00, "R4 unmapped high read");
    // R10 FIFO
    fifo_valid = 1'b1; fifo_data = 8'h9C;
    host_read(2'b10, 8'h9C, "R10 fifo head");
    chk(pops == 1, "R10 one pop", pops, 1);
    fifo_valid = 1'b0;
    host_read(2'b10, 8'h00, "R10 empty fifo read");
    chk(pops == 1, "R10 no pop when empty", pops, 1);
    // R5 slow read, R7 busy then done
    expect_req(1'b0, 8'h12, 8'h00);
    host_write(2'b00, 8'h12);
    host_read(2'b11, 8'h02, "R7 busy during slow read");
    wait_acks(1);
    host_read(2'b11, 8'h01, "R7 done after slow read");
    host_read(2'b01, slow_val(8'h12), "R5 slow read result");
    // R8 launch while busy dropped
    expect_req(1'b0, 8'h10, 8'h00);
    host_write(2'b00, 8'h10);
    host_write(2'b00, 8'h20);
    host_read(2'b11, 8'h02, "R8 still busy, done cleared by launch");
    wait_acks(2);
    host_read(2'b01, slow_val(8'h10), "R8 dropped launch left first result");
    chk(req_q.size() == 0 && !slow_req, "R8 no extra request", slow_req, 0);
    // R6 slow write (pointer write first launches a read)
    expect_req(1'b0, 8'h40, 8'h00);
    host_write(2'b00, 8'h40);
    wait_acks(3);
    expect_req(1'b1, 8'h40, 8'h77);
    host_write(2'b01, 8'h77);
    host_read(2'b11, 8'h02, "R7 write launch clears done");
    wait_acks(4);
    host_read(2'b11, 8'h01, "R6 write completion flag");
    host_write(2'b11, 8'h02);
    host_read(2'b11, 8'h01, "R7 write without bit0 keeps flag");
    // R9 interrupt
    chk(irq === 1'b0, "R9 irq masked", irq, 0);
    host_write(2'b00, 8'hC1); host_write(2'b01, 8'h01);
    chk(irq === 1'b1, "R9 irq enabled with done", irq, 1);
    host_write(2'b11, 8'h01);
    chk(irq === 1'b0, "R9 irq after clear", irq, 0);
    host_read(2'b11, 8'h00, "R7 write-one-to-clear");
    expect_req(1'b0, 8'h8F, 8'h00);
    host_write(2'b00, 8'h8F);
    chk(irq === 1'b0, "R9 irq low while busy", irq, 0);
    wait_acks(5);
    chk(irq === 1'b1, "R9 irq on slow completion", irq, 1);
    host_read(2'b01, slow_val(8'h8F), "R5 slow region top edge");
    host_write(2'b00, 8'hC1); host_write(2'b01, 8'h00);
    chk(irq === 1'b0, "R9 irq masked with done set", irq, 0);
    host_read(2'b11, 8'h01, "R3 fast write leaves flag");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule